// File: doc/BRIEF.md
# Ternary Longest-Prefix Lookup Table

This block resolves an IPv4 destination address to a next-hop identifier. It holds a small table of ternary entries. Each entry carries a 32-bit key, a 32-bit care mask and a next-hop code. A mask bit of 1 means the address bit must equal the key bit. A mask bit of 0 means the bit is ignored. Every valid entry is compared against the address at once. Among the entries that match, the one with the lowest index wins, and its next hop is returned with a hit flag one clock later.

Software, or a route engine, fills the table through a write port that addresses one entry by index. It must place longer prefixes at lower indices, so that entry order stands for prefix length. A prefix of length L is written with its upper L mask bits set and the rest cleared. A length-0 entry sits last as a default route. The lookup port takes a new address every cycle.

Top module: `lpm_ternary_table`

## Requirements
- R1: After reset every entry is invalid, and rs_valid, rs_hit and rs_nh are 0; a lookup issued right after reset misses.
- R2: rs_valid in a cycle equals lk_valid of the previous cycle, and the block accepts a lookup every cycle, each result belonging to the address presented one cycle earlier.
- R3: A valid entry matches when, for every bit i with mask bit i = 1, address bit i equals key bit i; bits whose mask bit is 0 are ignored.
- R4: When several entries match, the next hop of the matching entry with the lowest index is returned.
- R5: When a lookup matches no entry, rs_hit is 0 and rs_nh is 0; in cycles where rs_valid is 0, rs_hit and rs_nh are also 0.
- R6: A write with wr_inval = 1 clears the valid bit of entry wr_idx; an invalid entry never matches, so a lookup falls through to the next matching entry or misses.
- R7: A write in the same cycle as a lookup is not seen by that lookup; it is seen by lookups issued in later cycles.
- R8: An entry with an all-zero mask (a /0 prefix) matches every address; with a /24 placed ahead of the /16 that contains it, an address inside the /24 returns the /24 next hop and one only inside the /16 returns the /16 next hop.
- R9: A write with wr_inval = 0 stores key, mask and next hop into entry wr_idx, marks it valid, and leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_inval | input | 1 | 1: clear entry wr_idx; 0: load entry wr_idx |
| wr_idx | input | 4 | Entry index to write (0 is highest priority) |
| wr_key | input | 32 | Key bits to store |
| wr_mask | input | 32 | Care mask to store (1 = compare, 0 = ignore) |
| wr_nh | input | 8 | Next-hop code to store |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Destination address to resolve |
| rs_valid | output | 1 | Result valid, one cycle after lk_valid |
| rs_hit | output | 1 | At least one valid entry matched |
| rs_nh | output | 8 | Next hop of the winning entry, 0 on miss |

## Verification
The bench targets nested prefixes, where a design that picked the highest index or the shortest mask would return the covering /16 or the /0 default instead of the /24. It flips bits on either side of each prefix boundary across many random table fills. A mask applied with reversed polarity, or an off-by-one boundary, would then hit on addresses outside the prefix. Invalidating a winner checks that a stale valid bit does not keep answering. A write that lands on the same edge as a lookup checks that the old table answers that lookup, and a design that bypassed the write would return the new hop one cycle early. Back-to-back lookups mixed with idle cycles expose results that are misaligned, or that leak a next hop through on a miss or an idle cycle.

// File: rtl/lpm_tt_pkg.sv
package lpm_tt_pkg;
   // priority encoder variants
   localparam int ENC_LINEAR  = 0;
   localparam int ENC_ISOLATE = 1;

   // default geometry
   localparam int DEF_KEY_W = 32;
   localparam int DEF_DEPTH = 16;
   localparam int DEF_NH_W  = 8;
endpackage

// File: rtl/lpm_tt_entry.sv
module lpm_tt_entry #(
   parameter int KEY_W  = 32,
   parameter int NH_W   = 8,
   parameter int IDX_W  = 4,
   parameter int MY_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_inval,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [KEY_W-1:0] wr_mask,
   input  logic [NH_W-1:0]  wr_nh,
   input  logic [KEY_W-1:0] lk_addr,
   output logic             match,
   output logic [NH_W-1:0]  nh
);
   localparam logic [IDX_W-1:0] SELF = IDX_W'(MY_IDX);

   logic             vld_q;
   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] care_q;
   logic [NH_W-1:0]  nh_q;
   logic             sel;
   logic [KEY_W-1:0] diff;

   assign sel = wr_en && (wr_idx == SELF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         key_q  <= '0;
         care_q <= '0;
         nh_q   <= '0;
      end else if (sel) begin
         if (wr_inval) begin
            vld_q <= 1'b0;
         end else begin
            vld_q  <= 1'b1;
            key_q  <= wr_key;
            care_q <= wr_mask;
            nh_q   <= wr_nh;
         end
      end
   end

   // bits that differ and are cared about
   assign diff  = (lk_addr ^ key_q) & care_q;
   assign match = vld_q && (diff == '0);
   assign nh    = nh_q;
endmodule

// File: rtl/lpm_tt_prio.sv
module lpm_tt_prio #(
   parameter int DEPTH     = 16,
   parameter int ENC_STYLE = 0
) (
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] gnt,
   output logic             any
);
   import lpm_tt_pkg::*;

   assign any = |req;

   generate
      if (ENC_STYLE == ENC_LINEAR) begin : g_linear
         always_comb begin
            logic found;
            found = 1'b0;
            gnt   = '0;
            for (int i = 0; i < DEPTH; i++) begin
               if (req[i] && !found) begin
                  gnt[i] = 1'b1;
                  found  = 1'b1;
               end
            end
         end
      end else begin : g_isolate
         // lowest set bit via two's complement
         assign gnt = req & (~req + DEPTH'(1));
      end
   endgenerate
endmodule

// File: rtl/lpm_tt_sel.sv
module lpm_tt_sel #(
   parameter int DEPTH = 16,
   parameter int NH_W  = 8
) (
   input  logic [DEPTH-1:0]           gnt,
   input  logic [DEPTH-1:0][NH_W-1:0] nh_all,
   output logic [NH_W-1:0]            nh_out
);
   always_comb begin
      nh_out = '0;
      for (int i = 0; i < DEPTH; i++) begin
         nh_out = nh_out | ({NH_W{gnt[i]}} & nh_all[i]);
      end
   end
endmodule

// File: rtl/lpm_ternary_table.sv
module lpm_ternary_table #(
   parameter int KEY_W     = lpm_tt_pkg::DEF_KEY_W,
   parameter int DEPTH     = lpm_tt_pkg::DEF_DEPTH,
   parameter int NH_W      = lpm_tt_pkg::DEF_NH_W,
   parameter int ENC_STYLE = lpm_tt_pkg::ENC_LINEAR,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_inval,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [KEY_W-1:0] wr_mask,
   input  logic [NH_W-1:0]  wr_nh,
   input  logic             lk_valid,
   input  logic [KEY_W-1:0] lk_addr,
   output logic             rs_valid,
   output logic             rs_hit,
   output logic [NH_W-1:0]  rs_nh
);
   import lpm_tt_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (KEY_W < 1 || NH_W < 1) begin : g_bad_width
         $error("KEY_W and NH_W must be positive");
      end
      if (ENC_STYLE != ENC_LINEAR && ENC_STYLE != ENC_ISOLATE) begin : g_bad_enc
         $error("ENC_STYLE selects an unknown encoder");
      end
   endgenerate

   logic [DEPTH-1:0]           hit_vec;
   logic [DEPTH-1:0][NH_W-1:0] nh_vec;
   logic [DEPTH-1:0]           gnt;
   logic                       any;
   logic [NH_W-1:0]            nh_win;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         lpm_tt_entry #(
            .KEY_W (KEY_W),
            .NH_W  (NH_W),
            .IDX_W (IDX_W),
            .MY_IDX(e)
         ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_inval(wr_inval),
            .wr_idx  (wr_idx),
            .wr_key  (wr_key),
            .wr_mask (wr_mask),
            .wr_nh   (wr_nh),
            .lk_addr (lk_addr),
            .match   (hit_vec[e]),
            .nh      (nh_vec[e])
         );
      end
   endgenerate

   lpm_tt_prio #(
      .DEPTH    (DEPTH),
      .ENC_STYLE(ENC_STYLE)
   ) u_prio (
      .req(hit_vec),
      .gnt(gnt),
      .any(any)
   );

   lpm_tt_sel #(
      .DEPTH(DEPTH),
      .NH_W (NH_W)
   ) u_sel (
      .gnt   (gnt),
      .nh_all(nh_vec),
      .nh_out(nh_win)
   );

   // result register; table writes land on the same edge, so this
   // lookup sees the table as it stood before that edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_nh    <= '0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= lk_valid && any;
         rs_nh    <= (lk_valid && any) ? nh_win : '0;
      end
   end
endmodule

// File: rtl/lpm_tt_checker.sv
module lpm_tt_checker #(
   parameter int DEPTH = 16,
   parameter int NH_W  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_inval,
   input logic [IDX_W-1:0] wr_idx,
   input logic             lk_valid,
   input logic             rs_valid,
   input logic             rs_hit,
   input logic [NH_W-1:0]  rs_nh
);
   logic             armed;
   logic [DEPTH-1:0] shadow_vld;
   logic             empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         shadow_vld <= '0;
         empty_q    <= 1'b1;
      end else begin
         armed   <= 1'b1;
         empty_q <= (shadow_vld == '0);
         if (wr_en) shadow_vld[wr_idx] <= !wr_inval;
      end
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rs_valid == $past(lk_valid)));

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |-> (!rs_hit && rs_nh == '0));

   p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_hit) |-> (rs_nh == '0));

   p_empty_misses_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && rs_valid && empty_q) |-> !rs_hit);
endmodule

bind lpm_ternary_table lpm_tt_checker #(
   .DEPTH(DEPTH),
   .NH_W (NH_W)
) u_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_inval(wr_inval),
   .wr_idx  (wr_idx),
   .lk_valid(lk_valid),
   .rs_valid(rs_valid),
   .rs_hit  (rs_hit),
   .rs_nh   (rs_nh)
);

// File: tb/lpm_ternary_table_bench.sv
module lpm_ternary_table_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_inval = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_key = '0, wr_mask = '0;
   logic [7:0]  wr_nh = '0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        rs_valid, rs_hit;
   logic [7:0]  rs_nh;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model of the table
   bit          m_v [DEPTH];
   logic [31:0] m_k [DEPTH];
   logic [31:0] m_m [DEPTH];
   logic [7:0]  m_n [DEPTH];
   logic [31:0] seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpm_ternary_table u_lpm_ternary_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_inval(wr_inval), .wr_idx(wr_idx),
      .wr_key(wr_key), .wr_mask(wr_mask), .wr_nh(wr_nh),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_nh(rs_nh)
   );

   function automatic logic [31:0] pmask(input int len);
      return (len == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len));
   endfunction

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   function automatic logic [8:0] model(input logic [31:0] a);
      for (int i = 0; i < DEPTH; i++)
         if (m_v[i] && (((a ^ m_k[i]) & m_m[i]) == 32'h0)) return {1'b1, m_n[i]};
      return 9'h0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input int idx, input logic [31:0] k, input int len, input logic [7:0] nh);
      @(negedge clk);
      wr_en = 1; wr_inval = 0; wr_idx = 4'(idx); wr_key = k; wr_mask = pmask(len); wr_nh = nh;
      @(negedge clk);
      wr_en = 0;
      m_v[idx] = 1; m_k[idx] = k; m_m[idx] = pmask(len); m_n[idx] = nh;
   endtask

   task automatic kill(input int idx);
      @(negedge clk);
      wr_en = 1; wr_inval = 1; wr_idx = 4'(idx);
      @(negedge clk);
      wr_en = 0; wr_inval = 0;
      m_v[idx] = 0;
   endtask

   task automatic look(input logic [31:0] a, input string tag);
      logic [8:0] e;
      e = model(a);
      @(negedge clk);
      lk_valid = 1; lk_addr = a;
      @(negedge clk);
      lk_valid = 0;
      check({tag, " valid"}, {31'h0, rs_valid}, 32'h1);
      check({tag, " hit"}, {31'h0, rs_hit}, {31'h0, e[8]});
      check({tag, " nh"}, {24'h0, rs_nh}, {24'h0, e[7:0]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_k[i] = 0; m_m[i] = 0; m_n[i] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rs_valid", {31'h0, rs_valid}, 32'h0);
      check("R1 rs_hit", {31'h0, rs_hit}, 32'h0);
      check("R1 rs_nh", {24'h0, rs_nh}, 32'h0);
      rst_n = 1;
      look(32'hFFFF_FFFF, "R1 empty lookup");
      look(32'h0, "R1 empty lookup zero");

      // R8/R4: nested prefixes, default route last
      put(0, 32'h0A01_0200, 24, 8'd11);
      put(1, 32'h0A01_0000, 16, 8'd12);
      put(2, 32'h0A00_0000, 8, 8'd13);
      put(5, 32'hC0A8_0000, 16, 8'd50);
      look(32'h0A01_0207, "R8 inside /24");
      look(32'h0A01_0307, "R8 inside /16 only");
      look(32'h0A02_0000, "R4 inside /8 only");
      look(32'hC0A8_FFFF, "R3 other /16");
      look(32'hC0A9_0000, "R3 bit past boundary");
      look(32'h0B01_0200, "R5 miss");
      put(15, 32'hDEAD_BEEF, 0, 8'd99);
      look(32'h0B01_0200, "R8 default route");
      look(32'h0A01_02FF, "R4 /24 beats default");

      // R6: invalidate the winner
      kill(0);
      look(32'h0A01_0207, "R6 falls to /16");
      kill(15);
      look(32'h0B01_0200, "R6 default gone");

      // R7: write and lookup on the same edge
      begin
         logic [8:0] old_e;
         old_e = model(32'h0A01_0207);
         @(negedge clk);
         wr_en = 1; wr_inval = 0; wr_idx = 4'd0; wr_key = 32'h0A01_0207;
         wr_mask = pmask(32); wr_nh = 8'd77;
         lk_valid = 1; lk_addr = 32'h0A01_0207;
         @(negedge clk);
         wr_en = 0; lk_valid = 0;
         check("R7 same-cycle nh old", {24'h0, rs_nh}, {24'h0, old_e[7:0]});
         m_v[0] = 1; m_k[0] = 32'h0A01_0207; m_m[0] = pmask(32); m_n[0] = 8'd77;
         look(32'h0A01_0207, "R7 later sees write");
      end

      // R2: back-to-back lookups with idle gaps
      begin
         logic [8:0] pe;
         logic       pv;
         pv = 0; pe = 0;
         for (int k = 0; k < 24; k++) begin
            logic [31:0] a;
            a = (k % 2) ? 32'h0A01_0000 + 32'(k) : 32'hC0A8_0000 ^ 32'(k << 20);
            @(negedge clk);
            if (k > 0) begin
               check("R2 rs_valid follows", {31'h0, rs_valid}, {31'h0, pv});
               check("R2 hit pipelined", {31'h0, rs_hit}, {31'h0, pe[8]});
               check("R5 nh pipelined", {24'h0, rs_nh}, {24'h0, pe[7:0]});
            end
            lk_valid = (k % 5) != 3;
            lk_addr = a;
            pv = lk_valid;
            pe = lk_valid ? model(a) : 9'h0;
         end
         @(negedge clk);
         lk_valid = 0;
         check("R2 last valid", {31'h0, rs_valid}, {31'h0, pv});
         check("R2 last nh", {24'h0, rs_nh}, {24'h0, pe[7:0]});
         @(negedge clk);
         check("R5 idle hit", {31'h0, rs_hit}, 32'h0);
         check("R5 idle nh", {24'h0, rs_nh}, 32'h0);
      end

      // R3/R4/R9: random table fills, addresses near each prefix
      for (int r = 0; r < 40; r++) begin
         for (int e = 0; e < DEPTH; e++) begin
            logic [31:0] x;
            x = rnd();
            if (x[3:0] == 4'd0) kill(e);
            else put(e, rnd(), int'(x[9:4]) % 33, 8'(e * 7 + r + 1));
         end
         for (int q = 0; q < 48; q++) begin
            logic [31:0] x, a;
            int j;
            x = rnd();
            j = int'(x[3:0]);
            case (x[5:4])
               2'd0: a = (m_k[j] & m_m[j]) | (rnd() & ~m_m[j]);
               2'd1: a = m_k[j] ^ (32'h1 << x[10:6]);
               2'd2: a = m_k[j];
               default: a = rnd();
            endcase
            look(a, "R3 R4 R9 sweep");
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule